// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer

This block lets ordinary static RAM or ROM sit on a 16-bit system bus whose address and data travel over the same set of active-low lines. When the bus master starts a cycle by asserting its sync strobe, the block takes the address from the shared lines, inverts it to positive logic, and holds it on a dedicated address output. Plain memory devices can then use that steady address for the rest of the cycle. The block also flags accesses to the top 8 KB of the address space, the I/O page.

For the data phase, the block watches the read and write strobes. It answers with a reply handshake when the latched address falls inside its memory window. On a read it drives the stored word back onto the shared lines, and on a write it updates either a whole word or a single byte. A word-wide memory array with one storage array per byte lane is part of the block, so the whole path can be tested alone. A no-memory test mode answers every cycle and returns zero on every read. The block takes no part in DMA or interrupts, so it passes both grant daisy chains straight from input to output.

The window starts at the parameter `MEM_BASE`, which must be word aligned, and spans `2*MEM_WORDS` bytes. A read followed by a write inside one sync period is answered twice, which covers read-modify-write cycles.

Top module: `mbus_demux`

## Requirements
- R1: On the first rising clock edge at which `sync_n_i` is sampled low, `addr_o` takes the bitwise inverse of `dal_n_i`. It keeps that value until the next such edge, including after sync is released.
- R2: `iopage_n_o` is 0 exactly when `addr_o[15:13]` is 3'b111, and 1 otherwise.
- R3: While sync is held, a low `din_n_i` or `dout_n_i` sampled at a clock edge makes `rply_n_o` go low right after that edge, if the address is selected. An address is selected when it lies in [MEM_BASE, MEM_BASE+2*MEM_WORDS), or always when `nomem_i` is 1. An address that is not selected never gets a reply.
- R4: After `din_n_i` and `dout_n_i` are both sampled high at a clock edge, `rply_n_o` is 1 right after that edge.
- R5: `dal_oe_o` is 1 only while both `din_n_i` and `rply_n_o` are low. While it is 1, `dal_n_o` carries the inverted stored word of the addressed location. `dal_oe_o` drops in the same cycle that `din_n_i` rises.
- R6: A write with `wtbt_n_i` high (word write) stores all 16 bits of the inverted data lines. Address bit 0 is ignored for word transfers.
- R7: A write with `wtbt_n_i` low (byte write) stores only one byte, taken from the matching data lanes. Address bit 0 = 0 selects bits 7:0 and address bit 0 = 1 selects bits 15:8. The other byte keeps its value.
- R8: With `nomem_i` = 1, every read returns all zeros (`dal_n_o` = 16'hFFFF), and writes leave the stored contents unchanged.
- R9: `dmg_out_n_o` follows `dmg_in_n_i` and `iak_out_n_o` follows `iak_in_n_i` with no clock delay.
- R10: After reset, `rply_n_o` = 1, `dal_oe_o` = 0, `addr_o` = 0 and `iopage_n_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples all bus strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| nomem_i | input | 1 | Test mode: answer every cycle, reads return zero, writes are dropped |
| dal_n_i | input | 16 | Shared address/data lines as received, active low |
| dal_n_o | output | 16 | Read data to drive onto the shared lines, active low |
| dal_oe_o | output | 1 | Enable for `dal_n_o`; lines are released when 0 |
| sync_n_i | input | 1 | Cycle start strobe, active low |
| din_n_i | input | 1 | Read data strobe, active low |
| dout_n_i | input | 1 | Write data strobe, active low |
| wtbt_n_i | input | 1 | Byte marker during a write data phase, active low |
| rply_n_o | output | 1 | Reply handshake, active low |
| addr_o | output | 16 | Latched positive-logic address |
| iopage_n_o | output | 1 | I/O page select, active low |
| dmg_in_n_i | input | 1 | DMA grant daisy-chain input |
| dmg_out_n_o | output | 1 | DMA grant daisy-chain output |
| iak_in_n_i | input | 1 | Interrupt acknowledge daisy-chain input |
| iak_out_n_o | output | 1 | Interrupt acknowledge daisy-chain output |

## Verification
A wrong latched address shows on `addr_o` and `iopage_n_o` one clock after sync is asserted. On a later read it also shows as data from the wrong location. A reply state machine that is stuck or leaves too early shows on `rply_n_o` within one clock of a strobe edge, either as a missing reply, a reply that never releases, or a reply to an address outside the window. A lost or misplaced byte-lane enable stays hidden until the location is read back, so every sweep writes the whole window and then reads all of it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int BUS_W   = 16;
    localparam int LANE_W  = 8;
    localparam int IO_BITS = 3;

    typedef enum logic [0:0] {
        XF_IDLE  = 1'b0,
        XF_REPLY = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
    import mbus_pkg::*;
#(
    parameter int W    = BUS_W,
    parameter int IO_W = IO_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_act_i,
    input  logic [W-1:0] dal_n_i,
    output logic         addr_ok_o,
    output logic [W-1:0] addr_o,
    output logic         iopage_n_o
);
    typedef struct packed {
        logic         sync_seen;
        logic [W-1:0] addr;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sync_seen = sync_act_i;
        if (sync_act_i && !st_q.sync_seen) begin
            st_d.addr = ~dal_n_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_ok_o  = st_q.sync_seen;
    assign addr_o     = st_q.addr;
    assign iopage_n_o = ~(&st_q.addr[W-1 -: IO_W]);
endmodule

// File: rtl/mbus_xfer_ctl.sv
module mbus_xfer_ctl
    import mbus_pkg::*;
#(
    parameter int          W     = BUS_W,
    parameter int          WORDS = 256,
    parameter int unsigned BASE  = 0,
    localparam int         NB    = W / LANE_W,
    localparam int         LB    = $clog2(NB),
    localparam int         AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_act_i,
    input  logic          addr_ok_i,
    input  logic [W-1:0]  addr_i,
    input  logic          din_act_i,
    input  logic          dout_act_i,
    input  logic          byte_i,
    input  logic          nomem_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  mem_rdata_i,
    output logic          rply_o,
    output logic          oe_o,
    output logic [W-1:0]  rdata_o,
    output logic          mem_we_o,
    output logic [NB-1:0] mem_be_o,
    output logic [AW-1:0] mem_idx_o,
    output logic [W-1:0]  mem_wdata_o
);
    localparam logic [W:0] WIN_LO = (W+1)'(BASE);
    localparam logic [W:0] WIN_HI = (W+1)'(BASE + 2 * WORDS);

    typedef struct packed {
        xfer_state_e  state;
        logic [W-1:0] rdata;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [W-1:0] off;
    logic         in_win;
    logic         hit;
    logic         unused_off;

    assign off        = addr_i - W'(BASE);
    assign in_win     = ({1'b0, addr_i} >= WIN_LO) && ({1'b0, addr_i} < WIN_HI);
    assign hit        = nomem_i || in_win;
    assign mem_idx_o  = off[AW+LB-1:LB];
    assign unused_off = ^{off[W-1:AW+LB]};

    always_comb begin
        st_d        = st_q;
        mem_we_o    = 1'b0;
        mem_be_o    = byte_i ? (NB'(1) << off[LB-1:0]) : {NB{1'b1}};
        mem_wdata_o = wdata_i;
        case (st_q.state)
            XF_IDLE: begin
                if (sync_act_i && addr_ok_i && hit && (din_act_i || dout_act_i)) begin
                    st_d.state = XF_REPLY;
                    if (din_act_i) begin
                        st_d.rdata = nomem_i ? '0 : mem_rdata_i;
                    end
                    if (dout_act_i && !din_act_i && !nomem_i) begin
                        mem_we_o = 1'b1;
                    end
                end
            end
            XF_REPLY: begin
                if (!sync_act_i || (!din_act_i && !dout_act_i)) begin
                    st_d.state = XF_IDLE;
                end
            end
            default: st_d.state = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: XF_IDLE, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rply_o  = (st_q.state == XF_REPLY);
    assign oe_o    = rply_o && din_act_i;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/mbus_mem.sv
module mbus_mem
    import mbus_pkg::*;
#(
    parameter int  W     = BUS_W,
    parameter int  WORDS = 256,
    localparam int NB    = W / LANE_W,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [NB-1:0] be_i,
    input  logic [AW-1:0] idx_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q [WORDS];

        always_ff @(posedge clk) begin
            if (we_i && be_i[g]) begin
                lane_q[idx_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = lane_q[idx_i];
    end
endmodule

// File: rtl/mbus_demux.sv
module mbus_demux
    import mbus_pkg::*;
#(
    parameter int          MEM_WORDS = 256,
    parameter int unsigned MEM_BASE  = 0,
    localparam int         W         = BUS_W,
    localparam int         NB        = W / LANE_W,
    localparam int         AW        = $clog2(MEM_WORDS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         nomem_i,
    input  logic [15:0]  dal_n_i,
    output logic [15:0]  dal_n_o,
    output logic         dal_oe_o,
    input  logic         sync_n_i,
    input  logic         din_n_i,
    input  logic         dout_n_i,
    input  logic         wtbt_n_i,
    output logic         rply_n_o,
    output logic [15:0]  addr_o,
    output logic         iopage_n_o,
    input  logic         dmg_in_n_i,
    output logic         dmg_out_n_o,
    input  logic         iak_in_n_i,
    output logic         iak_out_n_o
);
    logic          addr_ok;
    logic          rply;
    logic [W-1:0]  rdata;
    logic          mem_we;
    logic [NB-1:0] mem_be;
    logic [AW-1:0] mem_idx;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata;

    mbus_addr_latch #(.W(W), .IO_W(IO_BITS)) i_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_act_i (~sync_n_i),
        .dal_n_i    (dal_n_i),
        .addr_ok_o  (addr_ok),
        .addr_o     (addr_o),
        .iopage_n_o (iopage_n_o)
    );

    mbus_xfer_ctl #(.W(W), .WORDS(MEM_WORDS), .BASE(MEM_BASE)) i_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_act_i  (~sync_n_i),
        .addr_ok_i   (addr_ok),
        .addr_i      (addr_o),
        .din_act_i   (~din_n_i),
        .dout_act_i  (~dout_n_i),
        .byte_i      (~wtbt_n_i),
        .nomem_i     (nomem_i),
        .wdata_i     (~dal_n_i),
        .mem_rdata_i (mem_rdata),
        .rply_o      (rply),
        .oe_o        (dal_oe_o),
        .rdata_o     (rdata),
        .mem_we_o    (mem_we),
        .mem_be_o    (mem_be),
        .mem_idx_o   (mem_idx),
        .mem_wdata_o (mem_wdata)
    );

    mbus_mem #(.W(W), .WORDS(MEM_WORDS)) i_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .be_i    (mem_be),
        .idx_i   (mem_idx),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    assign rply_n_o    = ~rply;
    assign dal_n_o     = ~rdata;
    assign dmg_out_n_o = dmg_in_n_i;
    assign iak_out_n_o = iak_in_n_i;
endmodule

// File: rtl/mbus_demux_chk.sv
module mbus_demux_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        nomem_i,
    input logic [15:0] dal_n_o,
    input logic        dal_oe_o,
    input logic        sync_n_i,
    input logic        din_n_i,
    input logic        dout_n_i,
    input logic        rply_n_o,
    input logic [15:0] addr_o,
    input logic        iopage_n_o
);
    assert_addr_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_n_i) |-> $stable(addr_o));

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sync_n_i, 1) && !$past(sync_n_i, 2)) |-> $stable(addr_o));

    assert_iopage_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(addr_o) |-> $stable(iopage_n_o));

    assert_reply_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rply_n_o) |-> $past(!sync_n_i && (!din_n_i || !dout_n_i)));

    assert_reply_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (din_n_i && dout_n_i) |=> rply_n_o);

    assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dal_oe_o |-> (!din_n_i && !rply_n_o));

    assert_nomem_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dal_oe_o && nomem_i && $stable(nomem_i)) |-> (dal_n_o == 16'hFFFF));
endmodule

bind mbus_demux mbus_demux_chk i_chk (.*);

// File: tb/test_mbus_demux.sv
module test_mbus_demux;
    localparam int          CLK_PERIOD = 10;
    localparam int          WORDS      = 16;
    localparam int unsigned BASE       = 32'h0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nomem = 1'b0;
    logic [15:0] dal_n = 16'hFFFF;
    logic [15:0] dal_n_o;
    logic        dal_oe;
    logic        sync_n = 1'b1, din_n = 1'b1, dout_n = 1'b1, wtbt_n = 1'b1;
    logic        rply_n;
    logic [15:0] addr;
    logic        iopage_n;
    logic        dmg_in = 1'b1, iak_in = 1'b1;
    logic        dmg_out, iak_out;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] ref_mem [WORDS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbus_demux #(.MEM_WORDS(WORDS), .MEM_BASE(BASE)) i_mbus_demux (
        .clk         (clk),
        .rst_n       (rst_n),
        .nomem_i     (nomem),
        .dal_n_i     (dal_n),
        .dal_n_o     (dal_n_o),
        .dal_oe_o    (dal_oe),
        .sync_n_i    (sync_n),
        .din_n_i     (din_n),
        .dout_n_i    (dout_n),
        .wtbt_n_i    (wtbt_n),
        .rply_n_o    (rply_n),
        .addr_o      (addr),
        .iopage_n_o  (iopage_n),
        .dmg_in_n_i  (dmg_in),
        .dmg_out_n_o (dmg_out),
        .iak_in_n_i  (iak_in),
        .iak_out_n_o (iak_out)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One complete bus cycle; for reads exp_rd is the expected positive-logic word.
    task automatic bus_xfer(input logic [15:0] a, input bit wr, input bit bytew,
                            input logic [15:0] wd, input bit sel,
                            input logic [15:0] exp_rd, input string rd_req);
        @(negedge clk);
        dal_n  = ~a;
        sync_n = 1'b0;
        @(negedge clk);
        chk(addr == a, "R1 capture", addr, a);
        chk(iopage_n == ((a[15:13] == 3'b111) ? 1'b0 : 1'b1), "R2 iopage", {15'd0, iopage_n}, a);
        if (wr) begin
            dal_n  = ~wd;
            wtbt_n = bytew ? 1'b0 : 1'b1;
            dout_n = 1'b0;
        end else begin
            dal_n = 16'hFFFF;
            din_n = 1'b0;
        end
        #1;
        chk(rply_n && !dal_oe, "R3 no early reply", {14'd0, rply_n, dal_oe}, 16'h2);
        @(negedge clk);
        if (sel) begin
            chk(!rply_n, "R3 reply", {15'd0, rply_n}, 16'h0);
            if (!wr) begin
                chk(dal_oe, "R5 drive", {15'd0, dal_oe}, 16'h1);
                chk(~dal_n_o == exp_rd, rd_req, ~dal_n_o, exp_rd);
            end
        end else begin
            for (int k = 0; k < 3; k++) begin
                chk(rply_n && !dal_oe, "R3 unselected", {14'd0, rply_n, dal_oe}, 16'h2);
                @(negedge clk);
            end
        end
        din_n  = 1'b1;
        dout_n = 1'b1;
        #1;
        chk(!dal_oe, "R5 release", {15'd0, dal_oe}, 16'h0);
        @(negedge clk);
        chk(rply_n, "R4 release", {15'd0, rply_n}, 16'h1);
        sync_n = 1'b1;
        wtbt_n = 1'b1;
        dal_n  = 16'hFFFF;
        @(negedge clk);
        chk(addr == a, "R1 hold", addr, a);
    endtask

    function automatic logic [15:0] waddr(input int i, input bit odd);
        return 16'(BASE + 2 * i) | {15'd0, odd};
    endfunction

    task automatic read_all(input string req);
        for (int i = 0; i < WORDS; i++) begin
            bus_xfer(waddr(i, 1'b0), 1'b0, 1'b0, 16'h0, 1'b1, ref_mem[i], req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(rply_n, "R10 rply", {15'd0, rply_n}, 16'h1);
        chk(!dal_oe, "R10 oe", {15'd0, dal_oe}, 16'h0);
        chk(addr == 16'h0, "R10 addr", addr, 16'h0);
        chk(iopage_n, "R10 iopage", {15'd0, iopage_n}, 16'h1);

        // R9 daisy chains, all four input combinations
        for (int c = 0; c < 4; c++) begin
            dmg_in = c[0];
            iak_in = c[1];
            #1;
            chk(dmg_out == c[0] && iak_out == c[1], "R9 chain", {14'd0, iak_out, dmg_out}, 16'(c));
        end
        dmg_in = 1'b1;
        iak_in = 1'b1;

        // R6 word writes over the whole window, odd addresses on odd words
        for (int i = 0; i < WORDS; i++) begin
            ref_mem[i] = 16'(i * 16'h1111) ^ 16'hA5C3;
            bus_xfer(waddr(i, i[0]), 1'b1, 1'b0, ref_mem[i], 1'b1, 16'h0, "R6");
        end
        read_all("R6 word readback");

        // R7 byte writes into each lane of each word
        for (int i = 0; i < WORDS; i++) begin
            for (int b = 0; b < 2; b++) begin
                logic [7:0] v;
                v = 8'(i * 7 + b * 93 + 1);
                if (b == 0) ref_mem[i][7:0] = v;
                else        ref_mem[i][15:8] = v;
                bus_xfer(waddr(i, b[0]), 1'b1, 1'b1, {v, v} ^ (b == 0 ? 16'hFF00 : 16'h00FF),
                         1'b1, 16'h0, "R7");
            end
            bus_xfer(waddr(i, 1'b0), 1'b0, 1'b0, 16'h0, 1'b1, ref_mem[i], "R7 byte readback");
        end

        // R3 unselected addresses: neither reply nor storage change
        bus_xfer(16'(BASE - 2), 1'b1, 1'b0, 16'h1234, 1'b0, 16'h0, "R3");
        bus_xfer(16'(BASE + 2 * WORDS), 1'b1, 1'b0, 16'h4321, 1'b0, 16'h0, "R3");
        bus_xfer(16'hFFFE, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R3");
        read_all("R3 contents intact");

        // R2 I/O page decode over every value of the top three address bits
        for (int v = 0; v < 8; v++) begin
            bus_xfer({v[2:0], 13'h0002}, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R2");
        end

        // R8 no-memory mode: replies everywhere, zero reads, writes dropped
        nomem = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            bus_xfer(waddr(i, 1'b0), 1'b1, 1'b0, 16'hFFFF, 1'b1, 16'h0, "R8");
            bus_xfer(waddr(i, 1'b0), 1'b0, 1'b0, 16'h0, 1'b1, 16'h0, "R8 zero read");
        end
        bus_xfer(16'hE010, 1'b0, 1'b0, 16'h0, 1'b1, 16'h0, "R8 zero read outside");
        bus_xfer(16'h0000, 1'b0, 1'b0, 16'h0, 1'b1, 16'h0, "R8 zero read outside");
        @(negedge clk);
        nomem = 1'b0;
        read_all("R8 writes dropped");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule